// File: doc/BRIEF.md
# Stuff-Controlled Tributary Enable Generator

This block gates one tributary out of a bit-interleaved multiplex. It runs on the high-rate clock. It advances only in cycles where an upstream strobe is high. That strobe is either tied high, so the block counts high-rate clock cycles, or it is the tributary enable of the stage above, so the block counts that stage's enable periods. A frame starts with a frame-start pulse. After that, the block drives its enable high for a series of information segments. One qualified period between segments is held low to stand for an overhead bit. After the last segment the enable stays low until the next frame start.

The segment pattern is picked by a three-bit mode code. A pattern has an optional leading segment of its own length, a number of equal body segments and a final segment. The final segment is one period shorter when the stuff-control input says the stuff position carries no data. The stuff control is taken when the final segment begins. A pulse marks the last enabled period of each frame, and the number of enabled periods in the frame is held on an output until the next frame ends.

Top module: `trib_gate_gen`

## Requirements
- R1: After reset, `en_o` and `frame_done_o` are low and `frame_total_o` is 0. No enable appears, even with `valid_i` high, until a frame-start pulse arrives.
- R2: `en_o` is high only in cycles where `valid_i` is high, and never in a cycle where `frame_start_i` is high.
- R3: Segment lengths by `mode_i` (lead; body length × body count; final full length): 0 = none; 84×7; 84. 1 = none; 48×5; 48. 2 = 93; 95×2; 95. 3 = 50; 52×2; 52. 4 = 53; 55×3; 55. The per-frame enable count is the sum of these lengths.
- R4: The first segment starts on the first qualified period after the frame start. Between two segments exactly one qualified period has `en_o` low.
- R5: When `stuff_data_i` is 1 the final segment has its full length. When it is 0 the final segment is one period shorter.
- R6: `stuff_data_i` is sampled on the first period of the final segment. Changes after that point do not change the current frame.
- R7: `frame_done_o` pulses together with the last enabled period of the frame. After it, `en_o` stays low until the next frame start.
- R8: A frame-start pulse in the middle of a frame restarts the pattern from its first segment.
- R9: From the cycle after `frame_done_o`, `frame_total_o` holds the number of enabled periods of the frame that just ended.
- R10: Mode codes 5 to 7 are reserved. A frame started under one of them produces no enable.
- R11: Cycles with `valid_i` low are not counted, so the segment pattern is the same whatever gaps the upstream strobe has.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start_i | input | 1 | Start-of-frame pulse; restarts the pattern |
| valid_i | input | 1 | Upstream qualifying strobe |
| stuff_data_i | input | 1 | 1: stuff position carries data (full final segment) |
| mode_i | input | 3 | Segment pattern select (codes in R3) |
| en_o | output | 1 | Tributary enable, high in qualified data periods |
| frame_done_o | output | 1 | High with the last enabled period of a frame |
| frame_total_o | output | CNT_W | Enabled-period count of the last completed frame |

## Verification
On every cycle, the assertions check these properties: the enable is qualified by the strobe and by the absence of a frame start, an overhead gap only follows an enabled period and lasts one qualified period, the block goes idle after the final segment, reserved modes stay silent, and completed totals stay within the range of the defined patterns. Other behaviour is shown only by the bench scenarios: the exact length of each segment, the effect of stuff control on the final segment, ignoring a late stuff change, mid-frame restarts and independence from strobe gaps. The bench sweeps every mode, both stuff values and several strobe patterns, and compares segment runs and totals against lengths it works out arithmetically.

// File: rtl/tg_pkg.sv
package tg_pkg;

  typedef enum logic [2:0] {
    TG_DS3_DS2 = 3'd0,
    TG_DS2_DS1 = 3'd1,
    TG_E3_E2   = 3'd2,
    TG_E2_E1   = 3'd3,
    TG_DS2_E1  = 3'd4
  } tg_mode_e;

  function automatic logic mode_known(logic [2:0] m);
    return m <= 3'd4;
  endfunction

  // length of the optional leading segment, 0 when absent
  function automatic int unsigned lead_len(logic [2:0] m);
    case (m)
      TG_E3_E2:  return 93;
      TG_E2_E1:  return 50;
      TG_DS2_E1: return 53;
      default:   return 0;
    endcase
  endfunction

  // length of each body segment, also the full final length
  function automatic int unsigned body_len(logic [2:0] m);
    case (m)
      TG_DS3_DS2: return 84;
      TG_DS2_DS1: return 48;
      TG_E3_E2:   return 95;
      TG_E2_E1:   return 52;
      TG_DS2_E1:  return 55;
      default:    return 1;
    endcase
  endfunction

  function automatic int unsigned body_cnt(logic [2:0] m);
    case (m)
      TG_DS3_DS2: return 7;
      TG_DS2_DS1: return 5;
      TG_E3_E2:   return 2;
      TG_E2_E1:   return 2;
      TG_DS2_E1:  return 3;
      default:    return 0;
    endcase
  endfunction

  function automatic int unsigned seg_count(logic [2:0] m);
    return ((lead_len(m) != 0) ? 1 : 0) + body_cnt(m) + 1;
  endfunction

  function automatic int unsigned seg_len(logic [2:0] m, int unsigned idx, logic full);
    if (idx == seg_count(m) - 1)
      return body_len(m) - (full ? 0 : 1);
    else if (lead_len(m) != 0 && idx == 0)
      return lead_len(m);
    else
      return body_len(m);
  endfunction

endpackage

// File: rtl/tg_seg_ctrl.sv
module tg_seg_ctrl #(
  parameter int SEG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fs,
  input  logic             start_ok,
  input  logic             adv,
  input  logic             per_last,
  input  logic             is_final,
  input  logic             stuff_take,
  input  logic             stuff_in,
  output logic             run,
  output logic             gap,
  output logic [SEG_W-1:0] seg_idx,
  output logic             stuff_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run     <= 1'b0;
      gap     <= 1'b0;
      seg_idx <= '0;
      stuff_q <= 1'b1;
    end else if (fs) begin
      run     <= start_ok;
      gap     <= 1'b0;
      seg_idx <= '0;
    end else if (adv) begin
      if (stuff_take)
        stuff_q <= stuff_in;
      if (gap) begin
        gap <= 1'b0;
      end else if (per_last) begin
        if (is_final) begin
          run <= 1'b0;
        end else begin
          seg_idx <= seg_idx + SEG_W'(1);
          gap     <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/tg_period_cnt.sv
module tg_period_cnt #(
  parameter int PER_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fs,
  input  logic             step,
  input  logic             wrap,
  output logic [PER_W-1:0] per_cnt
);

  always_ff @(posedge clk) begin
    if (!rst_n)
      per_cnt <= '0;
    else if (fs)
      per_cnt <= '0;
    else if (step)
      per_cnt <= wrap ? '0 : per_cnt + PER_W'(1);
  end

endmodule

// File: rtl/tg_tally.sv
module tg_tally #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fs,
  input  logic             step,
  input  logic             close,
  output logic [CNT_W-1:0] total
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nx;

  assign cnt_nx = cnt + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      total <= '0;
    end else begin
      if (fs)
        cnt <= '0;
      else if (step)
        cnt <= cnt_nx;
      if (close && !fs)
        total <= cnt_nx;
    end
  end

endmodule

// File: rtl/trib_gate_gen.sv
module trib_gate_gen
  import tg_pkg::*;
#(
  parameter int PER_W = 7,
  parameter int SEG_W = 4,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start_i,
  input  logic             valid_i,
  input  logic             stuff_data_i,
  input  logic [2:0]       mode_i,
  output logic             en_o,
  output logic             frame_done_o,
  output logic [CNT_W-1:0] frame_total_o
);

  logic             run_w;
  logic             gap_w;
  logic [SEG_W-1:0] seg_w;
  logic             stuff_q;
  logic [PER_W-1:0] per_w;

  logic             adv_w;
  logic             is_final_w;
  logic             stuff_eff_w;
  logic             stuff_take_w;
  logic [PER_W-1:0] last_idx_w;
  logic             per_last_w;

  assign adv_w        = valid_i & run_w & ~frame_start_i;
  assign en_o         = adv_w & ~gap_w;
  assign is_final_w   = (seg_w == SEG_W'(seg_count(mode_i) - 1));
  assign stuff_take_w = en_o & is_final_w & (per_w == '0);
  assign stuff_eff_w  = (is_final_w && per_w == '0) ? stuff_data_i : stuff_q;
  assign last_idx_w   = PER_W'(seg_len(mode_i, int'(seg_w), stuff_eff_w) - 1);
  assign per_last_w   = en_o & (per_w == last_idx_w);
  assign frame_done_o = per_last_w & is_final_w;

  tg_seg_ctrl #(.SEG_W(SEG_W)) u_seg (
    .clk       (clk),
    .rst_n     (rst_n),
    .fs        (frame_start_i),
    .start_ok  (mode_known(mode_i)),
    .adv       (adv_w),
    .per_last  (per_last_w),
    .is_final  (is_final_w),
    .stuff_take(stuff_take_w),
    .stuff_in  (stuff_data_i),
    .run       (run_w),
    .gap       (gap_w),
    .seg_idx   (seg_w),
    .stuff_q   (stuff_q)
  );

  tg_period_cnt #(.PER_W(PER_W)) u_per (
    .clk    (clk),
    .rst_n  (rst_n),
    .fs     (frame_start_i),
    .step   (en_o),
    .wrap   (per_last_w),
    .per_cnt(per_w)
  );

  tg_tally #(.CNT_W(CNT_W)) u_tally (
    .clk  (clk),
    .rst_n(rst_n),
    .fs   (frame_start_i),
    .step (en_o),
    .close(frame_done_o),
    .total(frame_total_o)
  );

endmodule

// File: rtl/tg_checker.sv
module tg_checker #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fs,
  input logic             valid,
  input logic [2:0]       mode,
  input logic             en,
  input logic             done,
  input logic             run,
  input logic             gap,
  input logic [CNT_W-1:0] total
);

  AST_EN_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (valid && !fs)); // R2

  AST_GAP_AFTER_SEG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gap) |-> $past(en)); // R4

  AST_GAP_ONE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (gap && valid && !fs) |=> !gap); // R4

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !run); // R7

  AST_RESERVED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode > 3'd4) |-> !en); // R10

  AST_TOTAL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (total >= CNT_W'(205) && total <= CNT_W'(672))); // R9

endmodule

bind trib_gate_gen tg_checker #(.CNT_W(CNT_W)) u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .fs   (frame_start_i),
  .valid(valid_i),
  .mode (mode_i),
  .en   (en_o),
  .done (frame_done_o),
  .run  (run_w),
  .gap  (gap_w),
  .total(frame_total_o)
);

// File: tb/trib_gate_gen_test.sv
module trib_gate_gen_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fs = 1'b0;
  logic       valid = 1'b0;
  logic       stuff = 1'b1;
  logic [2:0] mode = 3'd0;
  logic       en;
  logic       done;
  logic [9:0] total;

  int checks = 0;
  int bad = 0;
  int cycles = 0;
  bit en_s, done_s;

  always #5 clk = ~clk;

  trib_gate_gen uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_start_i(fs),
    .valid_i      (valid),
    .stuff_data_i (stuff),
    .mode_i       (mode),
    .en_o         (en),
    .frame_done_o (done),
    .frame_total_o(total)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      bad++;
      checks++;
      $display("FAIL watchdog: run did not end, actual=%0d cycles expected<150000", cycles);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bench's own view of the patterns: lead, body, count
  function automatic int t_lead(int m);
    if (m == 2) return 93;
    if (m == 3) return 50;
    if (m == 4) return 53;
    return 0;
  endfunction
  function automatic int t_body(int m);
    int b[5] = '{84, 48, 95, 52, 55};
    return b[m];
  endfunction
  function automatic int t_cnt(int m);
    int c[5] = '{7, 5, 2, 2, 3};
    return c[m];
  endfunction
  function automatic int t_nseg(int m);
    return (t_lead(m) > 0 ? 1 : 0) + t_cnt(m) + 1;
  endfunction
  function automatic int t_len(int m, int k, bit st);
    if (k == t_nseg(m) - 1) return t_body(m) - (st ? 0 : 1);
    if (k == 0 && t_lead(m) > 0) return t_lead(m);
    return t_body(m);
  endfunction
  function automatic int t_total(int m, bit st);
    return t_lead(m) + t_cnt(m) * t_body(m) + t_body(m) - (st ? 0 : 1);
  endfunction
  function automatic bit vpat(int vp, int c);
    if (vp == 1) return (c % 3) != 2;
    if (vp == 2) return (c % 4) == 0;
    return 1'b1;
  endfunction

  task automatic step(input bit f, input bit v, input bit s);
    @(negedge clk);
    fs = f;
    valid = v;
    stuff = s;
    #4;
    en_s = en;
    done_s = done;
  endtask

  task automatic run_frame(input int m, input bit st, input int vp, input bit flip, input int restart_at);
    int k = 0, run = 0, enc = 0, lows = 0;
    bit seen = 0, restarted = 0;
    int nseg = t_nseg(m);
    int exp_tot = t_total(m, st);
    mode = 3'(m);
    step(1'b1, 1'b1, st);
    check(!en_s, "R2 frame-start cycle", int'(en_s), 0);
    for (int c = 0; c < 4000 && !seen; c++) begin
      bit v = vpat(vp, c);
      bit f = 1'b0;
      bit s = (flip && k == nseg - 1 && run >= 2) ? !st : st;
      if (restart_at > 0 && enc == restart_at && !restarted) begin
        f = 1'b1;
        restarted = 1'b1;
      end
      step(f, v, s);
      if (f) begin
        check(!en_s, "R8 restart cycle quiet", int'(en_s), 0);
        k = 0; run = 0; enc = 0; lows = 0;
        continue;
      end
      if (en_s && !v) check(0, "R2 enable without valid", 1, 0);
      if (v) begin
        if (en_s) begin
          if (run == 0) check(lows == ((k == 0) ? 0 : 1), "R4 gap periods", lows, (k == 0) ? 0 : 1);
          lows = 0;
          run++;
          enc++;
        end else begin
          lows++;
          if (run > 0) begin
            check(run == t_len(m, k, st), "R3 segment length", run, t_len(m, k, st));
            k++;
            run = 0;
          end
        end
      end
      if (done_s) begin
        seen = 1'b1;
        check(k == nseg - 1, "R7 done on final segment", k, nseg - 1);
        check(run == t_len(m, k, st), flip ? "R6 final length with late stuff change" : "R5 final length", run, t_len(m, k, st));
        check(enc == exp_tot, restart_at > 0 ? "R8 total after restart" : "R11 frame enable count", enc, exp_tot);
      end
    end
    check(seen, "R7 done seen", int'(seen), 1);
    step(1'b0, 1'b1, st);
    check(int'(total) == exp_tot, "R9 frame total", int'(total), exp_tot);
    for (int i = 0; i < 30; i++) begin
      step(1'b0, 1'b1, st);
      if (en_s) check(0, "R7 enable after frame end", 1, 0);
    end
    check(!en_s, "R7 idle after frame", int'(en_s), 0);
  endtask

  initial begin
    int quiet;
    repeat (3) @(negedge clk);
    #4;
    check(!en && !done, "R1 reset outputs", int'(en), 0);
    check(total == 0, "R1 reset total", int'(total), 0);
    @(negedge clk);
    rst_n = 1'b1;
    quiet = 0;
    for (int i = 0; i < 20; i++) begin
      step(1'b0, 1'b1, 1'b1);
      if (en_s) quiet++;
    end
    check(quiet == 0, "R1 no enable before frame start", quiet, 0);

    for (int m = 0; m < 5; m++)
      for (int st = 0; st < 2; st++)
        for (int vp = 0; vp < 2; vp++)
          run_frame(m, st[0], vp, 1'b0, 0);
    run_frame(1, 1'b1, 2, 1'b0, 0);
    run_frame(1, 1'b0, 2, 1'b0, 0);

    run_frame(2, 1'b1, 0, 1'b1, 0);
    run_frame(3, 1'b0, 1, 1'b1, 0);

    run_frame(0, 1'b1, 0, 1'b0, 100);
    run_frame(4, 1'b0, 1, 1'b0, 50);

    for (int m = 5; m < 8; m++) begin
      mode = 3'(m);
      step(1'b1, 1'b1, 1'b1);
      quiet = 0;
      for (int i = 0; i < 200; i++) begin
        step(1'b0, 1'b1, 1'b1);
        if (en_s) quiet++;
      end
      check(quiet == 0, "R10 reserved mode silent", quiet, 0);
    end

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule